// File: doc/BRIEF.md
# Pipelined CORDIC Square Root

This block returns the square root of a signed fixed-point sample. It has W bits in total, with BP of them after the binary point. The result uses the same format. It accepts one sample per clock, and every result appears a fixed number of cycles after its sample.

The computation rests on the identity sqrt(w) = sqrt((w+0.25)² − (w−0.25)²). The first pipeline step takes the absolute value of the input and flags a zero input. The magnitude is then normalised into [0.25, 1) with an exponent that is always even, so that half of it can be undone exactly at the end. A chain of hyperbolic vectoring stages follows. Each stage can be registered or left combinational on its own. The last steps remove the CORDIC gain, undo the halved exponent with rounding, and apply the sign of the input. A zero input forces the result to zero.

A negative input gives the negated root of its magnitude. The most negative code is accepted, but its result is not guaranteed. BP must lie between 0 and W−1.

Top module: `csqrt_unit`

## Requirements
- R1: While reset is asserted, and until the first result arrives, out_valid is 0 and out_data is 0.
- R2: Every accepted input produces exactly one output exactly LAT cycles later, where LAT = 7 + (W−BP) + ((W−BP) mod 2) + the number of registered rotation stages. No output appears without a matching input.
- R3: For a positive input x, out_data lies within 2 LSB of round(sqrt(x·2^BP)). Here x is read as a two's-complement integer and out_data as a signed integer, and the result is strictly positive.
- R4: An input of 0 gives an output of exactly 0.
- R5: For a negative input x other than the most negative code, out_data lies within 2 LSB of −round(sqrt(|x|·2^BP)), and the result is strictly negative.
- R6: R3 also holds for the smallest magnitudes, down to 1 LSB. This covers both odd and even leading-zero counts in the normalisation step.
- R7: R3 also holds for inputs at and near the largest positive code.
- R8: Inputs presented on consecutive cycles produce results on consecutive cycles, with no gap and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present on in_data this cycle |
| in_data | input | W | Signed input sample with BP fraction bits |
| out_valid | output | 1 | Result present on out_data this cycle |
| out_data | output | W | Signed square root with BP fraction bits |

## Verification
The hardest path to reach is the odd-exponent correction for magnitudes that are only a few LSBs. In that case the normaliser shifts right by one bit into its extra low bit, and the final shift is at its largest. Reaching it needs inputs chosen by their leading-zero count rather than by value, so the stimulus walks every small magnitude from 1 to 31 and several powers of two. Zero is also interleaved between live samples, which shows that its flag stays aligned with its own data through the stream. A long back-to-back burst that mixes signs keeps every stage full, while the per-result latency is checked on every output.

// File: rtl/csqrt_pkg.sv
package csqrt_pkg;

    // Shift positions that are applied twice so that the hyperbolic
    // iteration converges.
    localparam int REPEAT_A = 4;
    localparam int REPEAT_B = 13;

    // Shift amount of rotation stage k (k counts from 0).
    function automatic int rot_shift(input int k);
        int  s;
        bit  done_a;
        bit  done_b;
        s      = 1;
        done_a = 1'b0;
        done_b = 1'b0;
        for (int j = 0; j < k; j++) begin
            if (s == REPEAT_A && !done_a)      done_a = 1'b1;
            else if (s == REPEAT_B && !done_b) done_b = 1'b1;
            else                               s++;
        end
        return s;
    endfunction

    // Product of the per-stage hyperbolic scale factors.
    function automatic real rot_gain(input int n);
        real g;
        g = 1.0;
        for (int k = 0; k < n; k++) begin
            g = g * $sqrt(1.0 - 2.0 ** (-2.0 * real'(rot_shift(k))));
        end
        return g;
    endfunction

    // Reciprocal of the gain, as an unsigned value with fb fraction bits.
    function automatic int gain_comp_q(input int n, input int fb);
        return $rtoi((2.0 ** real'(fb)) / rot_gain(n) + 0.5);
    endfunction

    // Number of set bits among the lowest n bits of v.
    function automatic int ones_in(input logic [63:0] v, input int n);
        int c;
        c = 0;
        for (int i = 0; i < 64; i++) begin
            if (i < n && v[i]) c++;
        end
        return c;
    endfunction

    // Total pipeline latency in cycles.
    function automatic int total_lat(input int w, input int bp, input int stage_sum);
        return 7 + (w - bp) + ((w - bp) % 2) + stage_sum;
    endfunction

endpackage

// File: rtl/csqrt_front.sv
module csqrt_front #(
    parameter int W  = 16,
    parameter int BP = 8,
    parameter int EW = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [W-1:0]         in_data,
    output logic                 o_valid,
    output logic                 o_neg,
    output logic                 o_zero,
    output logic [W:0]           o_frac,
    output logic signed [EW-1:0] o_ehalf
);
    localparam int NF = W + 1;
    localparam int K  = W - BP;

    typedef struct packed {
        logic         valid;
        logic         neg;
        logic         zero;
        logic [W-1:0] mag;
    } cond_t;

    typedef struct packed {
        logic                 valid;
        logic                 neg;
        logic                 zero;
        logic [NF-1:0]        frac;
        logic signed [EW-1:0] ehalf;
    } norm_t;

    typedef struct packed {
        cond_t c;
        norm_t n;
    } front_t;

    front_t st_d, st_q;

    always_comb begin
        int           lz;
        int           expo;
        logic [W-1:0] shifted;

        // Stage 1: sign removal and zero detection.
        st_d.c.valid = in_valid;
        st_d.c.neg   = in_data[W-1];
        st_d.c.zero  = (in_data == '0);
        st_d.c.mag   = in_data[W-1] ? (~in_data + 1'b1) : in_data;

        // Stage 2: leading-zero count; the loop keeps the highest set bit.
        lz = W;
        for (int i = 0; i < W; i++) begin
            if (st_q.c.mag[i]) lz = W - 1 - i;
        end
        shifted = st_q.c.mag << lz;
        expo    = K - lz;

        st_d.n.valid = st_q.c.valid;
        st_d.n.neg   = st_q.c.neg;
        st_d.n.zero  = st_q.c.zero;
        if (expo % 2 != 0) begin
            // Odd exponent: back off one bit into the extra LSB.
            st_d.n.frac = {1'b0, shifted};
            expo        = expo + 1;
        end else begin
            st_d.n.frac = {shifted, 1'b0};
        end
        st_d.n.ehalf = EW'(expo / 2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign o_valid = st_q.n.valid;
    assign o_neg   = st_q.n.neg;
    assign o_zero  = st_q.n.zero;
    assign o_frac  = st_q.n.frac;
    assign o_ehalf = st_q.n.ehalf;

    // R3: a non-zero magnitude leaves normalisation inside [0.25, 1).
    a_r3_norm_range: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_zero) |-> (o_frac[NF-1:NF-2] != 2'b00));

endmodule

// File: rtl/csqrt_rot.sv
module csqrt_rot #(
    parameter int DW  = 23,
    parameter int EW  = 7,
    parameter int SH  = 1,
    parameter bit REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 i_valid,
    input  logic                 i_neg,
    input  logic                 i_zero,
    input  logic signed [EW-1:0] i_ehalf,
    input  logic signed [DW-1:0] i_x,
    input  logic signed [DW-1:0] i_y,
    output logic                 o_valid,
    output logic                 o_neg,
    output logic                 o_zero,
    output logic signed [EW-1:0] o_ehalf,
    output logic signed [DW-1:0] o_x,
    output logic signed [DW-1:0] o_y
);
    typedef struct packed {
        logic                 valid;
        logic                 neg;
        logic                 zero;
        logic signed [EW-1:0] ehalf;
        logic signed [DW-1:0] x;
        logic signed [DW-1:0] y;
    } rot_t;

    rot_t st_d;

    always_comb begin
        logic signed [DW-1:0] xs;
        logic signed [DW-1:0] ys;
        xs = i_x >>> SH;
        ys = i_y >>> SH;
        st_d.valid = i_valid;
        st_d.neg   = i_neg;
        st_d.zero  = i_zero;
        st_d.ehalf = i_ehalf;
        if (i_y[DW-1]) begin
            st_d.x = i_x + ys;
            st_d.y = i_y + xs;
        end else begin
            st_d.x = i_x - ys;
            st_d.y = i_y - xs;
        end
    end

    generate
        if (REG) begin : g_reg
            rot_t st_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end
            assign o_valid = st_q.valid;
            assign o_neg   = st_q.neg;
            assign o_zero  = st_q.zero;
            assign o_ehalf = st_q.ehalf;
            assign o_x     = st_q.x;
            assign o_y     = st_q.y;
        end else begin : g_comb
            assign o_valid = st_d.valid;
            assign o_neg   = st_d.neg;
            assign o_zero  = st_d.zero;
            assign o_ehalf = st_d.ehalf;
            assign o_x     = st_d.x;
            assign o_y     = st_d.y;
        end
    endgenerate

    // R3: for a live non-zero sample the X coordinate stays positive.
    a_r3_x_positive: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && !i_zero) |-> (i_x > 0));

endmodule

// File: rtl/csqrt_back.sv
module csqrt_back #(
    parameter int W    = 16,
    parameter int BP   = 8,
    parameter int DW   = 23,
    parameter int CF   = 20,
    parameter int EW   = 7,
    parameter int NSTG = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 i_valid,
    input  logic                 i_neg,
    input  logic                 i_zero,
    input  logic signed [EW-1:0] i_ehalf,
    input  logic signed [DW-1:0] i_x,
    output logic                 o_valid,
    output logic [W-1:0]         o_data
);
    import csqrt_pkg::*;

    localparam int             GC     = gain_comp_q(NSTG, CF);
    localparam logic [CF+1:0]  GAIN_C = (CF + 2)'(GC);
    localparam int             PW     = DW + CF + 2;

    typedef struct packed {
        logic                 valid;
        logic                 neg;
        logic                 zero;
        logic signed [EW-1:0] ehalf;
        logic [DW-1:0]        mag;
    } scl_t;

    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } res_t;

    typedef struct packed {
        scl_t s;
        res_t r;
    } back_t;

    back_t st_d, st_q;

    always_comb begin
        logic signed [PW-1:0] prod;
        logic [DW-1:0]        rnd;
        int                   sh;

        // Stage A: remove the hyperbolic gain.
        prod = PW'(i_x) * PW'($signed({1'b0, GAIN_C}));
        st_d.s.valid = i_valid;
        st_d.s.neg   = i_neg;
        st_d.s.zero  = i_zero;
        st_d.s.ehalf = i_ehalf;
        st_d.s.mag   = DW'(prod >>> CF);

        // Stage B: undo the halved exponent with rounding, then apply the
        // sign and the zero override. The parameters keep sh at 1 or above.
        sh  = CF - BP - int'($signed(st_q.s.ehalf));
        rnd = (st_q.s.mag + (DW'(1) << (sh - 1))) >> sh;
        st_d.r.valid = st_q.s.valid;
        if (st_q.s.zero)     st_d.r.data = '0;
        else if (st_q.s.neg) st_d.r.data = W'(~rnd + 1'b1);
        else                 st_d.r.data = W'(rnd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign o_valid = st_q.r.valid;
    assign o_data  = st_q.r.data;

    // R4: the zero flag yields an exact zero two cycles on.
    a_r4_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && i_zero) |=> ##1 (o_valid && o_data == '0));

    // R5: a negative sample leaves with a negative result.
    a_r5_neg_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && !i_zero && i_neg) |=> ##1 (o_valid && $signed(o_data) < 0));

    // R3: a positive sample leaves with a positive result.
    a_r3_pos_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && !i_zero && !i_neg) |=> ##1 (o_valid && $signed(o_data) > 0));

endmodule

// File: rtl/csqrt_unit.sv
module csqrt_unit #(
    parameter int               W       = 16,
    parameter int               BP      = 8,
    parameter int               N_STG   = 16,
    parameter logic [N_STG-1:0] STG_REG = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    import csqrt_pkg::*;

    localparam int NF      = W + 1;
    localparam int GUARD   = 3;
    localparam int CF      = NF + GUARD;
    localparam int DW      = CF + 3;
    localparam int EW      = $clog2(W + 2) + 2;
    localparam int STG_SUM = ones_in(64'(STG_REG), N_STG);
    localparam int LAT     = total_lat(W, BP, STG_SUM);
    localparam int PAD     = LAT - 4 - STG_SUM;
    localparam int CW      = $clog2(LAT + 2) + 1;

    localparam logic signed [DW-1:0] QUARTER = DW'(1) << (CF - 2);

    logic                 f_valid, f_neg, f_zero;
    logic [NF-1:0]        f_frac;
    logic signed [EW-1:0] f_ehalf;

    csqrt_front #(.W(W), .BP(BP), .EW(EW)) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_data (in_data),
        .o_valid (f_valid),
        .o_neg   (f_neg),
        .o_zero  (f_zero),
        .o_frac  (f_frac),
        .o_ehalf (f_ehalf)
    );

    logic                 c_valid [N_STG+1];
    logic                 c_neg   [N_STG+1];
    logic                 c_zero  [N_STG+1];
    logic signed [EW-1:0] c_ehalf [N_STG+1];
    logic signed [DW-1:0] c_x     [N_STG+1];
    logic signed [DW-1:0] c_y     [N_STG+1];
    logic signed [DW-1:0] frac_w;

    // Seed vector: X = v + 1/4, Y = v - 1/4.
    assign frac_w     = DW'({f_frac, {GUARD{1'b0}}});
    assign c_valid[0] = f_valid;
    assign c_neg[0]   = f_neg;
    assign c_zero[0]  = f_zero;
    assign c_ehalf[0] = f_ehalf;
    assign c_x[0]     = frac_w + QUARTER;
    assign c_y[0]     = frac_w - QUARTER;

    generate
        for (genvar k = 0; k < N_STG; k++) begin : g_stage
            csqrt_rot #(
                .DW (DW),
                .EW (EW),
                .SH (rot_shift(k)),
                .REG(STG_REG[k])
            ) u_rot (
                .clk    (clk),
                .rst_n  (rst_n),
                .i_valid(c_valid[k]),
                .i_neg  (c_neg[k]),
                .i_zero (c_zero[k]),
                .i_ehalf(c_ehalf[k]),
                .i_x    (c_x[k]),
                .i_y    (c_y[k]),
                .o_valid(c_valid[k+1]),
                .o_neg  (c_neg[k+1]),
                .o_zero (c_zero[k+1]),
                .o_ehalf(c_ehalf[k+1]),
                .o_x    (c_x[k+1]),
                .o_y    (c_y[k+1])
            );
        end
    endgenerate

    logic         b_valid;
    logic [W-1:0] b_data;

    csqrt_back #(.W(W), .BP(BP), .DW(DW), .CF(CF), .EW(EW), .NSTG(N_STG)) u_back (
        .clk    (clk),
        .rst_n  (rst_n),
        .i_valid(c_valid[N_STG]),
        .i_neg  (c_neg[N_STG]),
        .i_zero (c_zero[N_STG]),
        .i_ehalf(c_ehalf[N_STG]),
        .i_x    (c_x[N_STG]),
        .o_valid(b_valid),
        .o_data (b_data)
    );

    // Alignment delay so that the total latency matches the closed form.
    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } pad_t;

    pad_t pad_d [PAD];
    pad_t pad_q [PAD];

    always_comb begin
        pad_d[0] = '{valid: b_valid, data: b_data};
        for (int i = 1; i < PAD; i++) pad_d[i] = pad_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        for (int i = 0; i < PAD; i++) begin
            if (!rst_n) pad_q[i] <= '0;
            else        pad_q[i] <= pad_d[i];
        end
    end

    assign out_valid = pad_q[PAD-1].valid;
    assign out_data  = pad_q[PAD-1].data;

    // Occupancy count that the latency properties below rely on.
    logic [CW-1:0] inflight_d, inflight_q;

    always_comb begin
        inflight_d = inflight_q;
        if (in_valid && !out_valid)      inflight_d = inflight_q + 1'b1;
        else if (!in_valid && out_valid) inflight_d = inflight_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inflight_q <= '0;
        else        inflight_q <= inflight_d;
    end

    // R2: never more samples in flight than the pipeline depth.
    a_r2_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= CW'(LAT));

    // R2: no result without an accepted sample.
    a_r2_no_orphan: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight_q != '0));

endmodule

// File: tb/csqrt_unit_tb.sv
module csqrt_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 16;
    localparam int BP  = 8;
    localparam int NS  = 16;
    localparam int LAT = 7 + (W - BP) + ((W - BP) % 2) + NS;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         out_valid;
    logic [W-1:0] out_data;

    csqrt_unit #(.W(W), .BP(BP), .N_STG(NS)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_data (out_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    q_exp [$];
    int    q_t   [$];
    string q_tag [$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_sqrt(input int x);
        int  m;
        int  v;
        if (x == 0) return 0;
        m = (x < 0) ? -x : x;
        v = $rtoi($sqrt(real'(m) * (2.0 ** BP)) + 0.5);
        return (x < 0) ? -v : v;
    endfunction

    task automatic send(input int x, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = W'(x);
        q_exp.push_back(ref_sqrt(x));
        q_t.push_back(cyc);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops the scoreboard on every result.
    always @(negedge clk) begin
        int    act;
        int    exp;
        int    t0;
        int    tol;
        int    diff;
        string tag;
        if (rst_n && out_valid) begin
            act = int'($signed(out_data));
            if (q_exp.size() == 0) begin
                check(1'b0, "R2", "output without input", act, 0);
            end else begin
                exp = q_exp.pop_front();
                t0  = q_t.pop_front();
                tag = q_tag.pop_front();
                tol = (tag == "R4") ? 0 : 2;
                diff = (act > exp) ? act - exp : exp - act;
                check(diff <= tol, tag, "result", act, exp);
                check((cyc - t0) == LAT, "R2", "latency", cyc - t0, LAT);
            end
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid in reset", int'(out_valid), 0);
        check(out_data == '0, "R1", "data in reset", int'(out_data), 0);
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1", "valid before input", int'(out_valid), 0);
        end

        // R3: positive values with gaps.
        send(256, "R3");   idle(2);
        send(1024, "R3");  send(64, "R3");   send(2304, "R3");
        send(25600, "R3"); send(1000, "R3"); send(77, "R3");
        idle(3);

        // R4: zero between live samples.
        send(0, "R4"); send(256, "R3"); send(0, "R4"); idle(1);

        // R5: negative values.
        send(-256, "R5"); send(-1024, "R5"); send(-12345, "R5"); send(-1, "R5");
        idle(2);

        // R6: small magnitudes, both leading-zero parities.
        for (int v = 1; v < 32; v++) send(v, "R6");
        send(64, "R6"); send(128, "R6");
        idle(2);

        // R7: largest positive codes.
        send(32767, "R7"); send(32766, "R7"); send(30000, "R7");
        send(16384, "R7"); send(16383, "R7");
        idle(2);

        // R8: long back-to-back burst with mixed signs.
        for (int i = 0; i < 48; i++) begin
            int v;
            v = (i * 1237 + 11) % 32768;
            send((i % 5 == 0) ? -v : v, "R8");
        end
        idle(1);

        repeat (LAT + 6) @(negedge clk);
        check(q_exp.size() == 0, "R2", "missing outputs", q_exp.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule